// File: doc/BRIEF.md
# Legacy DMA Channel Register Emulator

This block presents the byte-wide I/O programming face of an old-style DMA controller channel to software, while a separate bus-master engine does the actual data movement. Software reaches the channel through I/O ports 00h to 07h and 0Ch. The block steers those byte accesses into 16-bit programmed base-address and base-count registers, and it answers reads with bytes of the engine's live address and byte counters.

A single shared byte-order flip-flop decides which half of a 16-bit value each access touches. Every access to ports 00h to 07h flips it. A write to 0Ch clears it. A full 16-bit value therefore takes two consecutive accesses, low byte first, after a clear. Reads are claimed only when the engine reports channel select code 000 and the status-read enable is set. In every other case the block leaves the cycle unclaimed and drives zero read data.

Top module: `dma_legacy_regs`

## Requirements
- R1: After reset, byte_hi is 0 and base_addr and base_count are 0.
- R2: Each clock cycle with io_rd or io_wr asserted and io_port in 0h to 7h inverts byte_hi exactly once. Any other cycle leaves byte_hi unchanged, except for a write to 0Ch.
- R3: A write to io_port 0Ch sets byte_hi to 0 at the next clock edge.
- R4: A write to io_port 0h loads io_wdata into base_addr[7:0] when byte_hi is 0, or into base_addr[15:8] when byte_hi is 1. This happens regardless of chan_code and stat_rd_en.
- R5: A write to io_port 1h loads io_wdata into base_count[7:0] when byte_hi is 0, or into base_count[15:8] when byte_hi is 1. This happens regardless of chan_code and stat_rd_en.
- R6: A claimed read of io_port 0h drives live_addr[7:0] when byte_hi is 0, or live_addr[15:8] when byte_hi is 1. The value appears combinationally in the same cycle as io_rd and uses byte_hi as it stood before that cycle's toggle.
- R7: A claimed read of io_port 1h drives live_count[7:0] when byte_hi is 0, or live_count[15:8] when byte_hi is 1, with the same timing as R6.
- R8: rd_claim is 1 exactly when io_rd is 1, io_port is 0h or 1h, chan_code is 000 and stat_rd_en is 1.
- R9: Whenever rd_claim is 0, rd_data is 0. This includes reads of 2h to 7h and 0Ch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_rd | input | 1 | I/O read strobe, one cycle per access |
| io_wr | input | 1 | I/O write strobe, one cycle per access |
| io_port | input | 4 | Decoded low I/O port number |
| io_wdata | input | 8 | Write data byte |
| chan_code | input | 3 | Channel select code from the transfer engine |
| stat_rd_en | input | 1 | Status-read enable; 1 allows reads to be answered |
| live_addr | input | 24 | Current address counter of the engine |
| live_count | input | 16 | Current byte counter of the engine |
| base_addr | output | 16 | Programmed base address |
| base_count | output | 16 | Programmed base count |
| byte_hi | output | 1 | Byte-order flip-flop (1 selects the high byte) |
| rd_claim | output | 1 | Read is answered by this block |
| rd_data | output | 8 | Read data byte |

## Verification
A read and a flip of the byte-order flip-flop fall in the same cycle. A read also flips the flag it depends on. The bench sweeps reads across every port, both flip-flop states, all eight channel codes and both enable values. For each read it checks the returned byte against the flip-flop state held before the access. It then confirms at the next sample that the state has inverted. Writes to 0Ch and to 00h or 01h are interleaved, so clears and two-byte loads can be judged against a bench-side model.

// File: rtl/dma_legacy_regs.sv
module dma_legacy_regs #(
  parameter int CA_W = 24,
  parameter int RW   = 16,
  parameter int DW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            io_rd,
  input  logic            io_wr,
  input  logic [3:0]      io_port,
  input  logic [DW-1:0]   io_wdata,
  input  logic [2:0]      chan_code,
  input  logic            stat_rd_en,
  input  logic [CA_W-1:0] live_addr,
  input  logic [RW-1:0]   live_count,
  output logic [RW-1:0]   base_addr,
  output logic [RW-1:0]   base_count,
  output logic            byte_hi,
  output logic            rd_claim,
  output logic [DW-1:0]   rd_data
);
  localparam logic [3:0] P_ADDR = 4'h0;
  localparam logic [3:0] P_CNT  = 4'h1;
  localparam logic [3:0] P_CLR  = 4'hC;

  wire chan_win = ~io_port[3];
  wire touch    = (io_rd | io_wr) & chan_win;
  wire clr      = io_wr & (io_port == P_CLR);
  wire wr_addr  = io_wr & (io_port == P_ADDR);
  wire wr_cnt   = io_wr & (io_port == P_CNT);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     byte_hi <= 1'b0;
    else if (clr)   byte_hi <= 1'b0;
    else if (touch) byte_hi <= ~byte_hi;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      base_addr  <= '0;
      base_count <= '0;
    end else begin
      if (wr_addr) begin
        if (byte_hi) base_addr[2*DW-1:DW] <= io_wdata;
        else         base_addr[DW-1:0]    <= io_wdata;
      end
      if (wr_cnt) begin
        if (byte_hi) base_count[2*DW-1:DW] <= io_wdata;
        else         base_count[DW-1:0]    <= io_wdata;
      end
    end

  wire [DW-1:0] addr_byte = byte_hi ? live_addr[2*DW-1:DW]  : live_addr[DW-1:0];
  wire [DW-1:0] cnt_byte  = byte_hi ? live_count[2*DW-1:DW] : live_count[DW-1:0];

  assign rd_claim = io_rd & stat_rd_en & (chan_code == 3'b000) &
                    ((io_port == P_ADDR) | (io_port == P_CNT));
  assign rd_data  = !rd_claim ? '0 : (io_port == P_ADDR) ? addr_byte : cnt_byte;
endmodule

module dma_legacy_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        io_rd,
  input logic        io_wr,
  input logic [3:0]  io_port,
  input logic [7:0]  io_wdata,
  input logic [15:0] base_addr,
  input logic [15:0] base_count,
  input logic        byte_hi,
  input logic        rd_claim,
  input logic [7:0]  rd_data
);
  // R2
  ptr_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((io_rd | io_wr) & ~io_port[3]) |=> (byte_hi != $past(byte_hi)));
  // R2
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(io_rd | io_wr)) |=> $stable(byte_hi));
  // R3
  ptr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr & io_port == 4'hC) |=> !byte_hi);
  // R4
  addr_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr & io_port == 4'h0 & !byte_hi) |=> (base_addr[7:0] == $past(io_wdata)));
  // R5
  cnt_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr & io_port == 4'h1 & byte_hi) |=> (base_count[15:8] == $past(io_wdata)));
  // R8
  claim_needs_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_claim |-> (io_rd & io_port[3:1] == 3'b000));
  // R9
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_claim |-> (rd_data == 8'h00));
endmodule

bind dma_legacy_regs dma_legacy_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .io_rd(io_rd), .io_wr(io_wr), .io_port(io_port),
  .io_wdata(io_wdata), .base_addr(base_addr), .base_count(base_count),
  .byte_hi(byte_hi), .rd_claim(rd_claim), .rd_data(rd_data)
);

// File: tb/sim_dma_legacy_regs.sv
module sim_dma_legacy_regs;
  logic clk = 0, rst_n = 0;
  logic io_rd = 0, io_wr = 0;
  logic [3:0] io_port = 0;
  logic [7:0] io_wdata = 0;
  logic [2:0] chan_code = 0;
  logic stat_rd_en = 1;
  logic [23:0] live_addr = 24'h5A_C3_7E;
  logic [15:0] live_count = 16'h91_2D;
  logic [15:0] base_addr, base_count;
  logic byte_hi, rd_claim;
  logic [7:0] rd_data;

  int nvec = 0, nbad = 0;
  logic m_hi = 0;
  logic [15:0] m_addr = 0, m_cnt = 0;

  always #5 clk = ~clk;

  dma_legacy_regs u0 (.*);

  task automatic chk(input string rq, input logic [31:0] got, input logic [31:0] exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s got=%0h exp=%0h", rq, got, exp);
    end
  endtask

  task automatic access(input logic rd, input logic wr, input logic [3:0] p,
                        input logic [7:0] d);
    logic claim_e;
    logic [7:0] data_e;
    @(negedge clk);
    io_rd = rd; io_wr = wr; io_port = p; io_wdata = d;
    #1;
    claim_e = rd && stat_rd_en && chan_code == 3'd0 && (p == 4'h0 || p == 4'h1);
    data_e = !claim_e ? 8'h00 : (p == 4'h0) ? (m_hi ? live_addr[15:8] : live_addr[7:0])
                                            : (m_hi ? live_count[15:8] : live_count[7:0]);
    if (rd) begin
      chk("R8 claim", rd_claim, claim_e);
      if (p == 4'h0) chk("R6 addr byte", rd_data, data_e);
      else if (p == 4'h1) chk("R7 count byte", rd_data, data_e);
      else chk("R9 quiet data", rd_data, data_e);
    end
    chk("R2 ptr", byte_hi, m_hi);
    @(posedge clk);
    if (wr && p == 4'h0) begin if (m_hi) m_addr[15:8] = d; else m_addr[7:0] = d; end
    if (wr && p == 4'h1) begin if (m_hi) m_cnt[15:8] = d; else m_cnt[7:0] = d; end
    if (wr && p == 4'hC) m_hi = 0;
    else if ((rd || wr) && !p[3]) m_hi = ~m_hi;
    #1;
    io_rd = 0; io_wr = 0;
  endtask

  initial begin
    #2_000_000;
    nbad++;
    $display("FAIL watchdog got=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    #12;
    chk("R1 ptr", byte_hi, 0);
    chk("R1 base_addr", base_addr, 0);
    chk("R1 base_count", base_count, 0);
    rst_n = 1;
    // R4 R5: two-byte loads under varied chan/enable
    for (int k = 0; k < 16; k++) begin
      chan_code = k[2:0]; stat_rd_en = k[3];
      access(0, 1, 4'hC, 8'h00);
      chk("R3 clear", byte_hi, 0);
      access(0, 1, 4'h0, 8'(k * 17 + 3));
      access(0, 1, 4'h0, 8'(k * 29 + 101));
      access(0, 1, 4'h1, 8'(k * 7 + 55));
      access(0, 1, 4'h1, 8'(k * 13 + 9));
      @(negedge clk);
      chk("R4 base_addr", base_addr, m_addr);
      chk("R5 base_count", base_count, m_cnt);
    end
    // R6 R7 R8 R9: read sweep, all ports, both pointer states
    for (int e = 0; e < 2; e++)
      for (int c = 0; c < 8; c++)
        for (int p = 0; p < 16; p++)
          for (int h = 0; h < 2; h++) begin
            stat_rd_en = e[0]; chan_code = c[2:0];
            live_addr = 24'(p * 4099 + c * 311 + h * 77 + 24'h10_2030);
            live_count = 16'(p * 523 + c * 97 + e * 4001 + h);
            access(0, 1, 4'hC, 8'h00);
            if (h == 1) access(0, 1, 4'h7, 8'hEE);
            access(1, 0, 4'(p), 8'h00);
            @(negedge clk);
            chk("R2 after read", byte_hi, m_hi);
          end
    // R2: non-channel ports leave pointer alone
    access(0, 1, 4'hC, 8'h00);
    access(1, 1, 4'h3, 8'h44);
    for (int p = 8; p < 16; p++) begin
      if (p != 12) access(0, 1, 4'(p), 8'hA5);
      access(1, 0, 4'(p), 8'h00);
      @(negedge clk);
      chk("R2 hold", byte_hi, m_hi);
    end
    @(negedge clk);
    chk("R4 final", base_addr, m_addr);
    chk("R5 final", base_count, m_cnt);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule